// File: doc/BRIEF.md
# Strided Access Bank Conflict Degree Calculator

This block predicts how badly a single warp-wide shared-memory access collides in the banks. Every lane `i` of a 32-lane warp reads word `i*s + b`, where `s` is the word stride and `b` a base word offset. Each of the 32 banks serves one distinct word per cycle. The block reports the worst number of lanes that pile onto one bank. That number is also the number of cycles the access takes. The block does not model the memory traffic itself.

The stride enters through a small front end that has four modes:
- a direct stride;
- a row length in words, for walking down one column of a row-major 2-D array;
- a structure size in words, for reading one field from every element of an array of structures;
- a same-word mode, in which every lane reads one word.

When the stride is zero, the single word is broadcast to all lanes in one cycle. The offset never changes the degree. It only decides which bank lane 0 starts on.

Beside the degree and cycle count, the block gives two more outputs:
- the repeat period, which is the lane distance after which a bank is reused;
- the number of distinct banks touched.

A request presented with `in_valid` is registered on the clock edge that samples it, and `out_valid` is high for the following cycle.

Top module: `stride_conflict_calc`

## Requirements
- R1: While `rst_n` is low and after its release, before any request, `out_valid` is 0, degree and cycles are 1, period and banks are 32, broadcast is 0 and start bank is 0.
- R2: A request with `in_valid` high at a rising edge sets `out_valid` high for the cycle after that edge; with `in_valid` low at an edge, `out_valid` is low after it.
- R3: For a nonzero stride `s`, the reported degree equals gcd(s, 32), which is 2 to the power of min(trailing zero bits of s, 5).
- R4: The reported cycle count always equals the reported degree.
- R5: Any odd stride gives degree 1, and any nonzero stride that is a multiple of 32 gives degree 32.
- R6: A zero stride gives degree 1, cycles 1, period 1, banks 1 and broadcast 1; any nonzero stride gives broadcast 0.
- R7: The offset has no effect on degree, cycles, period, banks or broadcast; the start bank equals the offset modulo 32 (its 5 low bits).
- R8: `in_mode` encodes 0 = direct stride, 1 = row length (stride = value), 2 = structure size in words (stride = value), 3 = same word (stride 0 whatever the value); so row length 33 gives degree 1, row length 32 gives degree 32, structure size 4 gives degree 4, size 3 gives degree 1.
- R9: For a nonzero stride, period and banks both equal 32 divided by the degree, so lanes i and i + period share a bank.
- R10: While `in_valid` is low, all result fields keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Stride source: 0 direct, 1 row length, 2 structure size, 3 same word |
| in_value | input | 16 | Stride, row length or structure size in words |
| in_offset | input | 16 | Base word offset of lane 0 |
| out_valid | output | 1 | Result valid, one cycle per request |
| out_degree | output | 6 | Worst lanes per bank |
| out_cycles | output | 6 | Cycles needed for the access |
| out_period | output | 6 | Lane distance at which a bank repeats |
| out_banks | output | 6 | Number of distinct banks touched |
| out_broadcast | output | 1 | All lanes read one word |
| out_start_bank | output | 5 | Bank used by lane 0 |

## Verification
On every cycle the assertions check four properties:
- the valid timing and the holding of the result while idle;
- the degree is a single power of two, and degree times period equals the lane count;
- a broadcast result is a one-bank, one-cycle result;
- an odd stride in any stride-carrying mode gives degree 1.

The exact gcd value, the mode mapping, the independence from the offset and the reset values can only be shown by the bench. It sweeps every stride from 0 to 1023 in all four modes and adds high-bit strides. It compares each field against a Euclid gcd computed in the bench.

// File: rtl/conflict_calc_pkg.sv
package conflict_calc_pkg;

    // Source of the stride for one request
    typedef enum logic [1:0] {
        MODE_STRIDE = 2'd0,
        MODE_ROW    = 2'd1,
        MODE_FIELD  = 2'd2,
        MODE_SAME   = 2'd3
    } walk_mode_e;

endpackage

// File: rtl/scc_stride_select.sv
module scc_stride_select
    import conflict_calc_pkg::*;
#(
    parameter int STRIDE_W = 16
) (
    input  walk_mode_e          mode,
    input  logic [STRIDE_W-1:0] value,
    output logic [STRIDE_W-1:0] stride
);

    always_comb begin
        unique case (mode)
            MODE_STRIDE: stride = value;  // given directly
            MODE_ROW:    stride = value;  // one row down = row length
            MODE_FIELD:  stride = value;  // next element = structure size
            MODE_SAME:   stride = '0;     // every lane on one word
            default:     stride = value;
        endcase
    end

endmodule

// File: rtl/scc_trailing_zeros.sv
module scc_trailing_zeros #(
    parameter int W    = 16,
    parameter int CAP  = 5,
    parameter int TZ_W = $clog2(CAP + 1)
) (
    input  logic [W-1:0]    stride,
    output logic [TZ_W-1:0] tz,
    output logic            is_zero
);

    // lz[k] is high when bits [k-1:0] of the stride are all zero
    logic [CAP:0] lz;
    assign lz[0] = 1'b1;

    for (genvar g = 0; g < CAP; g++) begin : g_chain
        assign lz[g+1] = lz[g] & ~stride[g];
    end

    always_comb begin
        tz = '0;
        for (int k = 1; k <= CAP; k++) begin
            tz = tz + TZ_W'(lz[k]);
        end
    end

    assign is_zero = ~|stride;

endmodule

// File: rtl/scc_degree_map.sv
module scc_degree_map #(
    parameter int LANES = 32,
    parameter int LOG   = $clog2(LANES),
    parameter int TZ_W  = $clog2(LOG + 1),
    parameter int CNT_W = LOG + 1
) (
    input  logic [TZ_W-1:0]  tz,
    input  logic             is_zero,
    output logic [CNT_W-1:0] degree,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] banks
);

    always_comb begin
        if (is_zero) begin
            degree = CNT_W'(1);
            period = CNT_W'(1);
            banks  = CNT_W'(1);
        end else begin
            degree = CNT_W'(1) << tz;
            period = CNT_W'(LANES) >> tz;
            banks  = CNT_W'(LANES) >> tz;
        end
    end

endmodule

// File: rtl/stride_conflict_calc.sv
module stride_conflict_calc
    import conflict_calc_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int STRIDE_W = 16,
    parameter int OFFS_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [1:0]                 in_mode,
    input  logic [STRIDE_W-1:0]        in_value,
    input  logic [OFFS_W-1:0]          in_offset,
    output logic                       out_valid,
    output logic [$clog2(LANES):0]     out_degree,
    output logic [$clog2(LANES):0]     out_cycles,
    output logic [$clog2(LANES):0]     out_period,
    output logic [$clog2(LANES):0]     out_banks,
    output logic                       out_broadcast,
    output logic [$clog2(LANES)-1:0]   out_start_bank
);

    localparam int LOG    = $clog2(LANES);
    localparam int CNT_W  = LOG + 1;
    localparam int TZ_W   = $clog2(LOG + 1);
    localparam int BANK_W = LOG;

    typedef struct packed {
        logic              valid;
        logic [CNT_W-1:0]  degree;
        logic [CNT_W-1:0]  period;
        logic [CNT_W-1:0]  banks;
        logic              bcast;
        logic [BANK_W-1:0] start;
    } res_t;

    localparam res_t RES_RST = '{
        valid:  1'b0,
        degree: CNT_W'(1),
        period: CNT_W'(LANES),
        banks:  CNT_W'(LANES),
        bcast:  1'b0,
        start:  '0
    };

    logic [STRIDE_W-1:0] stride;
    logic [TZ_W-1:0]     tz;
    logic                is_zero;
    logic [CNT_W-1:0]    deg_c, per_c, bnk_c;
    logic                unused_offset_hi;

    res_t res_d, res_q;

    scc_stride_select #(.STRIDE_W(STRIDE_W)) i_select (
        .mode   (walk_mode_e'(in_mode)),
        .value  (in_value),
        .stride (stride)
    );

    scc_trailing_zeros #(.W(STRIDE_W), .CAP(LOG), .TZ_W(TZ_W)) i_tz (
        .stride  (stride),
        .tz      (tz),
        .is_zero (is_zero)
    );

    scc_degree_map #(.LANES(LANES), .LOG(LOG), .TZ_W(TZ_W), .CNT_W(CNT_W)) i_map (
        .tz      (tz),
        .is_zero (is_zero),
        .degree  (deg_c),
        .period  (per_c),
        .banks   (bnk_c)
    );

    // only the bank-select bits of the offset matter
    assign unused_offset_hi = ^in_offset[OFFS_W-1:BANK_W];

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.degree = deg_c;
            res_d.period = per_c;
            res_d.banks  = bnk_c;
            res_d.bcast  = is_zero;
            res_d.start  = in_offset[BANK_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= RES_RST;
        else        res_q <= res_d;
    end

    assign out_valid      = res_q.valid;
    assign out_degree     = res_q.degree;
    assign out_cycles     = res_q.degree;
    assign out_period     = res_q.period;
    assign out_banks      = res_q.banks;
    assign out_broadcast  = res_q.bcast;
    assign out_start_bank = res_q.start;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_degree) && $stable(out_period) &&
                       $stable(out_broadcast) && $stable(out_start_bank)));

    // R3
    degree_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_degree) == 1));

    // R9
    period_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_broadcast) |->
            (32'(out_degree) * 32'(out_period) == 32'(LANES)));

    // R6
    broadcast_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_broadcast) |-> (out_cycles == CNT_W'(1) && out_banks == CNT_W'(1)));

    // R5
    odd_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_value[0] && in_mode != 2'd3) |=> (out_degree == CNT_W'(1)));

endmodule

// File: tb/test_stride_conflict_calc.sv
`timescale 1ns/1ps
module test_stride_conflict_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'd0;
    logic [15:0] in_value = '0;
    logic [15:0] in_offset = '0;
    logic        out_valid;
    logic [5:0]  out_degree, out_cycles, out_period, out_banks;
    logic        out_broadcast;
    logic [4:0]  out_start_bank;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    stride_conflict_calc i_stride_conflict_calc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_value(in_value), .in_offset(in_offset), .out_valid(out_valid),
        .out_degree(out_degree), .out_cycles(out_cycles), .out_period(out_period),
        .out_banks(out_banks), .out_broadcast(out_broadcast),
        .out_start_bank(out_start_bank)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int gcd(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // drive one request at a falling edge and check it one cycle later
    task automatic run(input int mode, input int value, input int offset);
        int s, deg, per;
        string t;
        in_valid  = 1'b1;
        in_mode   = 2'(mode);
        in_value  = 16'(value);
        in_offset = 16'(offset);
        @(negedge clk);
        s   = (mode == 3) ? 0 : value;
        deg = (s == 0) ? 1 : gcd(s, 32);
        per = (s == 0) ? 1 : 32 / deg;
        if (mode == 1 || mode == 2)          t = "R8 degree";
        else if (s == 0)                     t = "R6 degree";
        else if (s % 2 == 1 || s % 32 == 0)  t = "R5 degree";
        else                                 t = "R3 degree";
        chk("R2 out_valid", int'(out_valid), 1);
        chk(t, int'(out_degree), deg);
        chk("R4 cycles", int'(out_cycles), deg);
        chk("R9 period", int'(out_period), per);
        chk("R9 banks", int'(out_banks), per);
        chk("R6 broadcast", int'(out_broadcast), (s == 0) ? 1 : 0);
        chk("R7 start bank", int'(out_start_bank), offset % 32);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 degree", int'(out_degree), 1);
        chk("R1 period", int'(out_period), 32);
        chk("R1 banks", int'(out_banks), 32);
        chk("R1 broadcast", int'(out_broadcast), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after release", int'(out_valid), 0);
        chk("R1 cycles after release", int'(out_cycles), 1);
        chk("R1 start bank", int'(out_start_bank), 0);

        // sweep: every stride 0..1023 in every mode
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 1024; s++) begin
                run(m, s, (s * 13 + m * 7) & 16'hFFFF);
            end
        end

        // high-bit strides
        run(0, 16'hFFFF, 3);
        run(0, 16'h8000, 40);
        run(0, 16'hFFE0, 65535);
        run(0, 16'h0030, 100);
        // R8 named cases
        run(1, 33, 7);
        run(1, 32, 7);
        run(2, 4, 0);
        run(2, 3, 0);
        run(3, 16'h0005, 7);

        // R7: stride 6 under several offsets keeps degree 2
        for (int k = 0; k < 6; k++) begin
            int offs [6] = '{0, 5, 9, 31, 32, 1000};
            run(0, 6, offs[k]);
            chk("R7 offset ignored degree", int'(out_degree), 2);
        end

        // R10 / R2: idle cycle with changed inputs holds the result
        run(0, 12, 9);
        in_valid  = 1'b0;
        in_value  = 16'd1;
        in_offset = 16'd20;
        in_mode   = 2'd3;
        @(negedge clk);
        chk("R2 idle out_valid", int'(out_valid), 0);
        chk("R10 hold degree", int'(out_degree), 4);
        chk("R10 hold period", int'(out_period), 8);
        chk("R10 hold start", int'(out_start_bank), 9);
        chk("R10 hold broadcast", int'(out_broadcast), 0);
        @(negedge clk);
        chk("R10 hold degree second", int'(out_degree), 4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule